// File: doc/BRIEF.md
# Dual-Enable Static Memory Core

This block models an 8192-word by 8-bit static memory. Its control pins follow an asynchronous-style decode. There are two chip selects of opposite polarity, an active-low output enable and an active-low write enable, and together they pick one of five modes: sleep, deselected, quiet, read or write. The bidirectional data pins are split into three signals: a write-data input, a read-data output and a drive-enable flag. A pad ring or a bus model outside the block uses the drive-enable flag to control the actual tri-state buffer.

Writes are registered. A location is written on a rising clock edge whenever the write condition holds at that edge. Reads are combinational: the read-data output follows the address in the same cycle while the block is in read mode. A registered standby flag shows whether the active-low select was high at the last clock edge. This mirrors the power-down state of the memory.

Reset is asynchronous and active-low, and its release is synchronised to the clock. Reset affects only the standby flag and leaves the stored words as they were.

Top module: `dual_en_sram`

## Requirements
- R1: Storage holds 8192 words of 8 bits, selected by a 13-bit address. Any word written can later be read back unchanged, including addresses 0 and 8191.
- R2: A word is written at a rising clock edge when sel_n=0, sel=1 and wr_n=0 at that edge. The level of rd_n has no effect on the write.
- R3: No word is written at an edge where sel_n=1, sel=0 or wr_n=1. The addressed location keeps its previous value.
- R4: When sel_n=0, sel=1, rd_n=0 and wr_n=1, drive_en=1 and rdata holds the word at the current address.
- R5: In read mode, rdata follows an address change within the same cycle, with no clock edge needed.
- R6: In every other combination of sel_n, sel, rd_n and wr_n, drive_en=0 and rdata=0. This includes wr_n=0 with rd_n=0.
- R7: After each rising edge, standby equals the value sel_n had at that edge. The level of sel does not affect standby.
- R8: While rst_n=0, standby is 0. Reset does not change stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and standby update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 13 | Word address |
| sel_n | input | 1 | Active-low chip select; when high, also selects power-down |
| sel | input | 1 | Active-high chip select |
| rd_n | input | 1 | Active-low output enable |
| wr_n | input | 1 | Active-low write enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not driving |
| drive_en | output | 1 | High only in read mode; enables the external bus driver |
| standby | output | 1 | Registered power-down status |

## Verification
The bench attempts writes in which exactly one of the three write conditions is inactive, then reads the location back. A decode that ignores one of the selects would overwrite the location. The bench also holds wr_n and rd_n low together. A design that let output enable win over write would raise drive_en there and fight the incoming data. The bench changes the address in read mode without any clock edge, which catches a registered read path. It also toggles sel alone while sel_n stays fixed, which shows whether standby was wrongly tied to the active-high select. Finally, it applies a reset in the middle of the run and then reads earlier data back, which catches a reset that clears the array.

// File: rtl/dual_en_sram_pkg.sv
package dual_en_sram_pkg;
  typedef enum logic [2:0] {
    MD_SLEEP = 3'd0,
    MD_OFF   = 3'd1,
    MD_QUIET = 3'd2,
    MD_READ  = 3'd3,
    MD_WRITE = 3'd4
  } sram_mode_e;
endpackage

// File: rtl/dual_en_sram_rst.sv
module dual_en_sram_rst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/dual_en_sram_dec.sv
module dual_en_sram_dec
  import dual_en_sram_pkg::*;
(
  input  logic       sel_n,
  input  logic       sel,
  input  logic       rd_n,
  input  logic       wr_n,
  output sram_mode_e mode,
  output logic       wr_fire,
  output logic       rd_fire
);
  always_comb begin
    if (sel_n)      mode = MD_SLEEP;
    else if (!sel)  mode = MD_OFF;
    else if (!wr_n) mode = MD_WRITE;
    else if (!rd_n) mode = MD_READ;
    else            mode = MD_QUIET;
  end

  assign wr_fire = (mode == MD_WRITE);
  assign rd_fire = (mode == MD_READ);
endmodule

// File: rtl/dual_en_sram_array.sv
module dual_en_sram_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
  end

  assign rword = cells[addr];
endmodule

// File: rtl/dual_en_sram.sv
module dual_en_sram
  import dual_en_sram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              drive_en,
  output logic              standby
);
  logic              rst_q;
  sram_mode_e        mode;
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] rword;
  logic              standby_d;

  dual_en_sram_rst #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  dual_en_sram_dec u_dec (
    .sel_n   (sel_n),
    .sel     (sel),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .mode    (mode),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire)
  );

  dual_en_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .wr_en (wr_fire),
    .addr  (addr),
    .wdata (wdata),
    .rword (rword)
  );

  assign drive_en = rd_fire;
  assign rdata    = rd_fire ? rword : '0;

  always_comb begin
    standby_d = (mode == MD_SLEEP);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) standby <= 1'b0;
    else        standby <= standby_d;
  end
endmodule

// File: rtl/dual_en_sram_chk.sv
module dual_en_sram_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q,
  input logic [ADDR_W-1:0] addr,
  input logic              sel_n,
  input logic              sel,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              drive_en,
  input logic              standby
);
  logic wr_cond;
  assign wr_cond = !sel_n && sel && !wr_n;

  // R6
  no_drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !wr_n |-> !drive_en);

  // R6
  quiet_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !drive_en |-> (rdata == '0));

  // R7
  standby_tracks_sel_n_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rst_q) |-> (standby == $past(sel_n)));

  // R2
  write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(wr_cond) && drive_en && (addr == $past(addr))) |-> (rdata == $past(wdata)));

  // R8
  reset_standby_low_chk: assert property (@(posedge clk)
    !rst_n |-> !standby);
endmodule

bind dual_en_sram dual_en_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_q    (rst_q),
  .addr     (addr),
  .sel_n    (sel_n),
  .sel      (sel),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .wdata    (wdata),
  .rdata    (rdata),
  .drive_en (drive_en),
  .standby  (standby)
);

// File: tb/sim_dual_en_sram.sv
module sim_dual_en_sram;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] addr;
  logic        sel_n, sel, rd_n, wr_n;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        drive_en, standby;

  int n_run = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_en_sram u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel(sel),
    .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata),
    .drive_en(drive_en), .standby(standby)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic set_pins(input logic sn, input logic s, input logic r, input logic w);
    sel_n = sn; sel = s; rd_n = r; wr_n = w;
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d, input logic oe_lvl);
    addr = a; wdata = d; set_pins(1'b0, 1'b1, oe_lvl, 1'b0);
    tick();
    set_pins(1'b0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic do_read(input logic [12:0] a, input logic [7:0] exp, input string req);
    addr = a; set_pins(1'b0, 1'b1, 1'b0, 1'b1);
    #1;
    check(req, rdata, exp);
    check({req, " drive"}, {7'd0, drive_en}, 8'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; addr = '0; wdata = '0;
    set_pins(1'b1, 1'b0, 1'b1, 1'b1);
    repeat (3) tick();
    check("R8 standby in reset", {7'd0, standby}, 8'd0);
    check("R6 no drive in reset", {7'd0, drive_en}, 8'd0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R7 standby after release", {7'd0, standby}, 8'd1);
  endtask

  task automatic t_write_read();
    do_write(13'd0,    8'hA5, 1'b1);
    do_write(13'd8191, 8'h3C, 1'b0);
    do_write(13'h1555, 8'h81, 1'b0);
    do_write(13'h0AAA, 8'h7E, 1'b1);
    do_read(13'd0,    8'hA5, "R1 addr0");
    do_read(13'd8191, 8'h3C, "R1 top addr");
    do_read(13'h1555, 8'h81, "R2 write with rd_n low");
    do_read(13'h0AAA, 8'h7E, "R4 read");
  endtask

  task automatic t_addr_follow();
    set_pins(1'b0, 1'b1, 1'b0, 1'b1);
    addr = 13'h1555; #1;
    check("R5 follow a", rdata, 8'h81);
    addr = 13'd8191; #1;
    check("R5 follow b", rdata, 8'h3C);
    addr = 13'd0; #1;
    check("R5 follow c", rdata, 8'hA5);
  endtask

  task automatic t_blocked();
    addr = 13'h0AAA; wdata = 8'h11; set_pins(1'b1, 1'b1, 1'b1, 1'b0);
    #1; check("R6 sleep no drive", {7'd0, drive_en}, 8'd0);
    tick();
    wdata = 8'h22; set_pins(1'b0, 1'b0, 1'b0, 1'b0);
    #1; check("R6 off no drive", {7'd0, drive_en}, 8'd0);
    check("R6 off rdata zero", rdata, 8'h00);
    tick();
    wdata = 8'h33; set_pins(1'b0, 1'b1, 1'b1, 1'b1);
    #1; check("R6 quiet no drive", {7'd0, drive_en}, 8'd0);
    tick();
    do_read(13'h0AAA, 8'h7E, "R3 blocked writes");
  endtask

  task automatic t_write_over_read();
    addr = 13'h0100; wdata = 8'h5A; set_pins(1'b0, 1'b1, 1'b0, 1'b0);
    #1;
    check("R6 write beats output enable", {7'd0, drive_en}, 8'd0);
    check("R6 rdata zero in write", rdata, 8'h00);
    tick();
    set_pins(1'b0, 1'b1, 1'b1, 1'b1);
    do_read(13'h0100, 8'h5A, "R2 write with both low");
  endtask

  task automatic t_standby();
    set_pins(1'b1, 1'b1, 1'b1, 1'b1);
    tick();
    check("R7 sleep sel high", {7'd0, standby}, 8'd1);
    set_pins(1'b1, 1'b0, 1'b1, 1'b1);
    tick();
    check("R7 sleep sel low", {7'd0, standby}, 8'd1);
    set_pins(1'b0, 1'b0, 1'b1, 1'b1);
    tick();
    check("R7 off not standby", {7'd0, standby}, 8'd0);
  endtask

  task automatic t_reset_keep();
    rst_n = 1'b0; set_pins(1'b1, 1'b1, 1'b1, 1'b1);
    tick();
    check("R8 standby held low", {7'd0, standby}, 8'd0);
    rst_n = 1'b1;
    repeat (3) tick();
    do_read(13'h1555, 8'h81, "R8 data kept");
    do_read(13'h0100, 8'h5A, "R8 data kept b");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_write_read();
        t_addr_follow();
        t_blocked();
        t_write_over_read();
        t_standby();
        t_reset_keep();
      end
      begin
        repeat (2000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule